// File: doc/BRIEF.md
# Dual Time-Match Alarm Interrupt Controller

This block watches the BCD time fields of a real-time clock and raises two active-low interrupt lines when the time reaches one of two programmed alarm settings. The weekly channel compares minute, hour and a seven-bit weekday mask. The daily channel compares minute and hour only. A single-cycle minute strobe marks the cycles in which the time fields hold a new minute, and comparisons are evaluated only on that strobe.

Software programs the alarm settings and a control register through a small register port. The write strobe and the address share one cycle, and read data is combinational from the address. Each channel has an enable bit and a status flag. A channel raises its flag only at the start of a matching minute. Enabling a channel while the time already equals its setting does not fire it. A flag stays set until software writes zero to it, and clearing a flag leaves the channel armed.

Top module: `dual_alarm_ctl`

## Requirements
- R1: After reset both interrupt outputs are high, and every register at addresses 0 to 5 reads 0.
- R2: Register map: address 0 holds the weekly minute in bits 6:0, address 1 the weekly hour in bits 5:0, address 2 the weekday mask in bits 6:0 (bit d selects weekday d, 0 to 6), address 3 the daily minute in bits 6:0, and address 4 the daily hour in bits 5:0. Address 5 is control, with weekly enable in bit 0, daily enable in bit 1, weekly flag in bit 4 and daily flag in bit 5. Bits outside a field are dropped on write and read as 0.
- R3: With the weekly channel enabled, a minute strobe where minute and hour equal the weekly setting and the mask bit of the current weekday is set (weekday 0 to 6) sets the weekly flag. The weekly output goes low in the cycle after that strobe. Weekday value 7 never matches.
- R4: With the daily channel enabled, a minute strobe where minute and hour equal the daily setting sets the daily flag on any weekday. The daily output goes low in the cycle after that strobe.
- R5: Setting an enable bit while the time already equals the alarm does not drive the output low. This also holds when the enable is written in the same cycle as a matching strobe. The output goes low only at a later strobe that brings a match.
- R6: Writing 0 to a flag bit clears it and returns the output high in the next cycle, and the enable bit keeps the written value. Writing 1 to a flag bit leaves the flag unchanged.
- R7: After a flag is cleared, the channel asserts again at its next match.
- R8: While a channel is disabled, its flag reads 0 and its output stays high. Disabling a channel with its flag set clears the flag.
- R9: If a match strobe and a write that clears the same flag fall in one cycle, the flag ends set and the output is low.
- R10: A strobe at which equality holds and the previous strobe of an enabled channel also matched does not set the flag again.
- R11: Each interrupt output is the inverse of its channel's flag as read at address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_wday | input | 3 | Current weekday, 0 to 6 |
| min_tick | input | 1 | One-cycle strobe marking a new minute on the time inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_wk_n | output | 1 | Weekly alarm interrupt, active low |
| irq_dy_n | output | 1 | Daily alarm interrupt, active low |

## Verification
A matching minute strobe and a control write can land in the same cycle. The bench provokes this twice. In one case the write clears a flag in the cycle of a new match, and the flag is expected to stay set. In the other the write sets the enable in the cycle of a matching strobe, and the output is expected to stay high. A behavioural model predicts both outputs and the read data at every clock, and directed checks confirm the outcome of each collision at the ports.

// File: rtl/dual_alarm_ctl.sv
module dual_alarm_ctl #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    cur_min,
  input  logic [5:0]    cur_hour,
  input  logic [2:0]    cur_wday,
  input  logic          min_tick,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq_wk_n,
  output logic          irq_dy_n
);

  localparam logic [AW-1:0] A_WMIN = AW'(0);
  localparam logic [AW-1:0] A_WHR  = AW'(1);
  localparam logic [AW-1:0] A_WDAY = AW'(2);
  localparam logic [AW-1:0] A_DMIN = AW'(3);
  localparam logic [AW-1:0] A_DHR  = AW'(4);
  localparam logic [AW-1:0] A_CTL  = AW'(5);

  logic [6:0] wk_min, wk_mask, dy_min;
  logic [5:0] wk_hr, dy_hr;
  logic [1:0] en, flag, pv, peq;

  logic       ctl_wr;
  logic [1:0] en_nxt, clr, eq, hit;
  logic [7:0] mask8;

  assign ctl_wr = reg_we && (reg_addr == A_CTL);
  assign en_nxt = ctl_wr ? reg_wdata[1:0] : en;
  assign clr    = ctl_wr ? ~reg_wdata[5:4] : 2'b00;
  assign mask8  = {1'b0, wk_mask};

  assign eq[0] = (cur_min == wk_min) && (cur_hour == wk_hr) && mask8[cur_wday];
  assign eq[1] = (cur_min == dy_min) && (cur_hour == dy_hr);
  assign hit   = en & {2{min_tick}} & eq & ~(pv & peq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_min  <= '0;
      wk_hr   <= '0;
      wk_mask <= '0;
      dy_min  <= '0;
      dy_hr   <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_WMIN:  wk_min  <= reg_wdata[6:0];
        A_WHR:   wk_hr   <= reg_wdata[5:0];
        A_WDAY:  wk_mask <= reg_wdata[6:0];
        A_DMIN:  dy_min  <= reg_wdata[6:0];
        A_DHR:   dy_hr   <= reg_wdata[5:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      flag <= '0;
      pv   <= '0;
      peq  <= '0;
    end else begin
      en   <= en_nxt;
      flag <= en_nxt & (hit | (flag & ~clr));
      if (min_tick) begin
        pv  <= en & en_nxt;
        peq <= eq;
      end else begin
        pv  <= pv & en_nxt;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_WMIN:  reg_rdata = {1'b0, wk_min};
      A_WHR:   reg_rdata = {2'b0, wk_hr};
      A_WDAY:  reg_rdata = {1'b0, wk_mask};
      A_DMIN:  reg_rdata = {1'b0, dy_min};
      A_DHR:   reg_rdata = {2'b0, dy_hr};
      A_CTL:   reg_rdata = {2'b0, flag, 2'b0, en};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq_wk_n = ~flag[0];
  assign irq_dy_n = ~flag[1];

  assert_wk_fall_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_wk_n) |-> $past(min_tick));

  assert_dy_fall_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_dy_n) |-> $past(min_tick));

  assert_wk_enable_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[0] && !en[0]) |=> irq_wk_n);

  assert_dy_enable_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[1] && !en[1]) |=> irq_dy_n);

  assert_wk_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !reg_wdata[4] && !hit[0]) |=> irq_wk_n);

  assert_dy_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !reg_wdata[5] && !hit[1]) |=> irq_dy_n);

  assert_wk_off_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en[0] |-> irq_wk_n);

  assert_dy_off_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en[1] |-> irq_dy_n);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && en_nxt[1]) |=> !irq_dy_n);

  assert_no_retrig_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && pv[1] && peq[1] && !ctl_wr) |=> (irq_dy_n == $past(irq_dy_n)));

endmodule

// File: tb/tb_dual_alarm_ctl.sv
module tb_dual_alarm_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [2:0] cur_wday = '0;
  logic       min_tick = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_wk_n, irq_dy_n;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  logic [6:0] m_wmin = '0, m_wmask = '0, m_dmin = '0;
  logic [5:0] m_whr = '0, m_dhr = '0;
  bit   m_en[2], m_flag[2], m_pv[2], m_peq[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_alarm_ctl dut (
    .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .min_tick(min_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_wk_n(irq_wk_n), .irq_dy_n(irq_dy_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {1'b0, m_wmin};
      3'd1: return {2'b0, m_whr};
      3'd2: return {1'b0, m_wmask};
      3'd3: return {1'b0, m_dmin};
      3'd4: return {2'b0, m_dhr};
      3'd5: return {2'b0, 1'(m_flag[1]), 1'(m_flag[0]), 2'b0, 1'(m_en[1]), 1'(m_en[0])};
      default: return 8'h00;
    endcase
  endfunction

  task automatic step();
    bit eq[2];
    bit nen[2], nflag[2], npv[2], npeq[2];
    bit ctl;
    eq[0] = (cur_min == m_wmin) && (cur_hour == m_whr) && (cur_wday < 7) && m_wmask[cur_wday];
    eq[1] = (cur_min == m_dmin) && (cur_hour == m_dhr);
    ctl = reg_we && reg_addr == 3'd5;
    for (int i = 0; i < 2; i++) begin
      bit hit, clr;
      hit  = m_en[i] && min_tick && eq[i] && !(m_pv[i] && m_peq[i]);
      nen[i] = ctl ? reg_wdata[i] : m_en[i];
      clr  = ctl && !reg_wdata[4+i];
      nflag[i] = nen[i] && (hit || (m_flag[i] && !clr));
      npv[i]  = min_tick ? (m_en[i] && nen[i]) : (m_pv[i] && nen[i]);
      npeq[i] = min_tick ? eq[i] : m_peq[i];
    end
    if (reg_we) begin
      case (reg_addr)
        3'd0: m_wmin  = reg_wdata[6:0];
        3'd1: m_whr   = reg_wdata[5:0];
        3'd2: m_wmask = reg_wdata[6:0];
        3'd3: m_dmin  = reg_wdata[6:0];
        3'd4: m_dhr   = reg_wdata[5:0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      m_en[i] = nen[i]; m_flag[i] = nflag[i]; m_pv[i] = npv[i]; m_peq[i] = npeq[i];
    end
    chk("R3 model irq_wk_n", {7'b0, irq_wk_n}, {7'b0, !m_flag[0]});
    chk("R4 model irq_dy_n", {7'b0, irq_dy_n}, {7'b0, !m_flag[1]});
    chk("R2 model rdata", reg_rdata, model_read(reg_addr));
    reg_we = 1'b0;
    min_tick = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic tick(input logic [6:0] mi, input logic [5:0] hr, input logic [2:0] wd);
    cur_min = mi; cur_hour = hr; cur_wday = wd; min_tick = 1'b1;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 reset irq_wk_n", {7'b0, irq_wk_n}, 8'h01);
    chk("R1 reset irq_dy_n", {7'b0, irq_dy_n}, 8'h01);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 8'h00);
    end

    wr(3'd0, 8'h30); wr(3'd1, 8'hC7); wr(3'd2, 8'h82);
    wr(3'd3, 8'hC5); wr(3'd4, 8'h12);
    rd(3'd1, d); chk("R2 weekly hour masked", d, 8'h07);
    rd(3'd2, d); chk("R2 weekday mask masked", d, 8'h02);
    rd(3'd3, d); chk("R2 daily minute masked", d, 8'h45);
    wr(3'd3, 8'h45);
    wr(3'd5, 8'h03);
    rd(3'd5, d); chk("R2 control enables", d, 8'h03);

    tick(7'h30, 6'h07, 3'd2);
    chk("R3 weekday not in mask", {7'b0, irq_wk_n}, 8'h01);
    tick(7'h30, 6'h07, 3'd1);
    chk("R3 weekly match", {7'b0, irq_wk_n}, 8'h00);
    chk("R3 daily untouched", {7'b0, irq_dy_n}, 8'h01);
    rd(3'd5, d); chk("R11 flag read matches output", d, 8'h13);

    wr(3'd5, 8'h03);
    chk("R6 weekly cleared", {7'b0, irq_wk_n}, 8'h01);
    rd(3'd5, d); chk("R6 enables kept", d, 8'h03);
    tick(7'h30, 6'h07, 3'd1);
    chk("R10 held match no retrigger", {7'b0, irq_wk_n}, 8'h01);

    tick(7'h45, 6'h12, 3'd5);
    chk("R4 daily match", {7'b0, irq_dy_n}, 8'h00);
    chk("R4 weekly stays high", {7'b0, irq_wk_n}, 8'h01);
    wr(3'd5, 8'h33);
    chk("R6 write one no effect", {7'b0, irq_dy_n}, 8'h00);
    rd(3'd5, d); chk("R6 flag kept", d, 8'h23);
    wr(3'd5, 8'h13);
    chk("R6 daily cleared", {7'b0, irq_dy_n}, 8'h01);
    rd(3'd5, d); chk("R6 enables after clear", d, 8'h03);

    tick(7'h46, 6'h12, 3'd0);
    tick(7'h45, 6'h12, 3'd0);
    chk("R7 rearmed match", {7'b0, irq_dy_n}, 8'h00);

    wr(3'd5, 8'h01);
    tick(7'h44, 6'h12, 3'd3);
    tick(7'h45, 6'h12, 3'd3);
    chk("R8 disabled no fire", {7'b0, irq_dy_n}, 8'h01);
    wr(3'd5, 8'h03);
    idle(3);
    chk("R5 enable during match", {7'b0, irq_dy_n}, 8'h01);
    tick(7'h46, 6'h12, 3'd3);
    chk("R5 no fire off match", {7'b0, irq_dy_n}, 8'h01);
    tick(7'h45, 6'h12, 3'd3);
    chk("R5 next occurrence fires", {7'b0, irq_dy_n}, 8'h00);

    wr(3'd5, 8'h01);
    tick(7'h44, 6'h12, 3'd3);
    cur_min = 7'h45; min_tick = 1'b1;
    reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h03;
    step();
    chk("R5 enable on matching strobe", {7'b0, irq_dy_n}, 8'h01);
    tick(7'h46, 6'h12, 3'd3);
    tick(7'h45, 6'h12, 3'd3);
    chk("R5 fires at later match", {7'b0, irq_dy_n}, 8'h00);

    wr(3'd5, 8'h21);
    chk("R8 disable clears flag", {7'b0, irq_dy_n}, 8'h01);
    rd(3'd5, d); chk("R8 flag reads zero", d, 8'h01);

    wr(3'd5, 8'h03);
    tick(7'h44, 6'h12, 3'd4);
    tick(7'h45, 6'h12, 3'd4);
    tick(7'h46, 6'h12, 3'd4);
    chk("R9 flag set before collision", {7'b0, irq_dy_n}, 8'h00);
    cur_min = 7'h45; min_tick = 1'b1;
    reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h03;
    step();
    chk("R9 match beats clear", {7'b0, irq_dy_n}, 8'h00);
    rd(3'd5, d); chk("R9 flag read", d, 8'h23);

    wr(3'd5, 8'h03);
    wr(3'd2, 8'hFF);
    tick(7'h00, 6'h07, 3'd1);
    tick(7'h30, 6'h07, 3'd7);
    chk("R3 weekday seven no match", {7'b0, irq_wk_n}, 8'h01);
    tick(7'h31, 6'h07, 3'd6);
    tick(7'h30, 6'h07, 3'd6);
    chk("R3 weekday six match", {7'b0, irq_wk_n}, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule